// File: doc/BRIEF.md
# Multi-Mode Countdown Timer Channel

This block is one channel of a down-counting timer. A rising edge on the enable input arms it: the counter takes the programmed load value and then steps toward zero. When it reaches zero it reloads, emits a one-cycle timeout pulse and raises a strobe that asks for the channel's timeout flag to be set. The pulse can also drive the chain input of the next channel or act as its trigger source.

The block has four counting behaviours. The full-width mode is a plain periodic counter. The split mode treats the word as two halves: the low half is the fast stage and the high half counts low-half underflows. The accumulate mode steps once per trigger event. The capture mode free-runs down from all ones and latches the bitwise inverse of the count whenever a trigger arrives. Three trigger controls apply on top of the mode: start-on-trigger, reload-on-trigger and halt-after-timeout. A chain option replaces the per-clock decrement with the previous channel's timeout pulse.

A period of N counts is programmed as N-1, and N must be greater than 2. The bus interface, interrupt masking and the grouping of channels are supplied by the surrounding design.

Top module: `cdt_channel`

## Requirements
- R1: A rising edge of `en` loads `count` from `load_val`, or with all ones when `mode` is 3. With `mode` 0 (full-width periodic), `count` then falls by one per clock. Once at zero, the next tick reloads `load_val`, so the timeout period is `load_val`+1 clocks.
- R2: Each expiry drives `timeout_pulse` and `flag_set` high together for exactly one clock.
- R3: A change of `load_val` while counting leaves the current count alone. The new value is first used at the next reload.
- R4: With `mode` 1 (split), the low half counts down alone. When the low half is zero, the next tick decrements the high half and reloads the low half from the low half of `load_val`. Expiry happens when both halves are zero.
- R5: With `mode` 2 (accumulate), the counter waits after enable until the first trigger event, which loads `load_val`. After that, each further trigger event decrements it, and an event at zero expires and reloads.
- R6: With `mode` 3 (capture), a trigger event sets `cap_val` to the bitwise inverse of `count` as it stood before that edge, and counting continues. Expiry at zero reloads all ones.
- R7: With `chain_en` high, the counter steps only in clocks where `chain_tick` is high.
- R8: With `start_on_trig` high, the count holds after enable until a trigger event, which loads `load_val` and starts the decrement.
- R9: With `reload_on_trig` high (modes 0, 1, 3), a trigger event while counting reloads the counter and produces no timeout.
- R10: With `stop_on_timeout` high, the channel holds its reloaded count after the first expiry and gives no further pulses until `en` rises again.
- R11: While `en` is low, `count` holds and no pulse occurs. Raising `en` again reloads from `load_val`.
- R12: A trigger event is a rising edge of `trig_in`. A level held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable; its rising edge arms and loads the channel |
| mode | input | 2 | 0 periodic, 1 split halves, 2 accumulate, 3 capture |
| load_val | input | CNT_W | Reload value (period minus one) |
| chain_en | input | 1 | Step on `chain_tick` instead of on every clock |
| start_on_trig | input | 1 | Wait for a trigger event before counting |
| reload_on_trig | input | 1 | A trigger event reloads the counter |
| stop_on_timeout | input | 1 | Halt after the first expiry |
| trig_in | input | 1 | Selected trigger source |
| chain_tick | input | 1 | Timeout pulse of the previous channel |
| count | output | CNT_W | Current counter value |
| cap_val | output | CNT_W | Inverted count latched in capture mode |
| timeout_pulse | output | 1 | One-clock expiry pulse, usable as a chain or trigger source |
| flag_set | output | 1 | Request to set the channel's timeout flag |

## Verification
The bench builds the channel with `CNT_W` = 8, so each half in split mode is 4 bits wide. At this width the all-ones start of capture mode expires after 256 ticks, and the bench follows that run through a full wrap and reload. The narrow halves also let a short load value such as 0x12 pass through a high-half borrow and a full expiry within a few clocks. Every mode, chain stepping and each trigger control can then be checked cycle by cycle against expected counts.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   // Counting behaviour selected by the mode input
   typedef enum logic [1:0] {
      CDT_PERIODIC  = 2'd0,
      CDT_SPLIT     = 2'd1,
      CDT_ACCUM     = 2'd2,
      CDT_CAPTURE   = 2'd3
   } cdt_mode_e;

   // Channel sequencing state
   typedef enum logic [1:0] {
      CS_WAIT = 2'd0,
      CS_RUN  = 2'd1,
      CS_HALT = 2'd2
   } cdt_state_e;

endpackage

// File: rtl/cdt_trig_edge.sv
module cdt_trig_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_evt
);

   logic trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig_in;
   end

   // one event per low-to-high transition
   assign trig_evt = trig_in & ~trig_q;

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
   import cdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] mode,
   input  logic       chain_en,
   input  logic       chain_tick,
   input  logic       start_on_trig,
   input  logic       reload_on_trig,
   input  logic       stop_on_timeout,
   input  logic       trig_evt,
   input  logic       cnt_zero,
   output logic       load_req,
   output logic       dec_req,
   output logic       cap_req,
   output logic       run_st,
   output logic       en_q,
   output logic       expire_q
);

   cdt_mode_e  md;
   cdt_state_e st_q, st_d;
   logic       en_rise, tick, expire;

   assign md      = cdt_mode_e'(mode);
   assign en_rise = en & ~en_q;

   // step qualifier: accumulate steps on triggers, otherwise clock or chain
   always_comb begin
      if (md == CDT_ACCUM) tick = trig_evt;
      else if (chain_en)   tick = chain_tick;
      else                 tick = 1'b1;
   end

   always_comb begin
      st_d     = st_q;
      load_req = 1'b0;
      dec_req  = 1'b0;
      cap_req  = 1'b0;
      expire   = 1'b0;
      if (en_rise) begin
         load_req = 1'b1;
         st_d     = (start_on_trig || md == CDT_ACCUM) ? CS_WAIT : CS_RUN;
      end else if (en) begin
         unique case (st_q)
            CS_WAIT: begin
               if (trig_evt) begin
                  load_req = 1'b1;
                  st_d     = CS_RUN;
               end
            end
            CS_RUN: begin
               cap_req = (md == CDT_CAPTURE) && trig_evt;
               if (reload_on_trig && trig_evt && md != CDT_ACCUM) begin
                  load_req = 1'b1;
               end else if (tick) begin
                  if (cnt_zero) begin
                     expire   = 1'b1;
                     load_req = 1'b1;
                     if (stop_on_timeout) st_d = CS_HALT;
                  end else begin
                     dec_req = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= CS_WAIT;
         en_q     <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         en_q     <= en;
         expire_q <= expire;
      end
   end

   assign run_st = (st_q == CS_RUN);

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_req,
   input  logic             dec_req,
   input  logic             cap_req,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_val,
   output logic             cnt_zero
);

   localparam int HALF_W = CNT_W / 2;
   localparam int LANES  = 2;

   cdt_mode_e        md;
   logic [CNT_W-1:0] reload_src, full_nxt, split_nxt, step_nxt;
   logic             lo_zero;

   assign md         = cdt_mode_e'(mode);
   assign reload_src = (md == CDT_CAPTURE) ? {CNT_W{1'b1}} : load_val;
   assign full_nxt   = count - 1'b1;
   assign lo_zero    = (count[HALF_W-1:0] == '0);
   assign cnt_zero   = (count == '0);

   // split mode: low lane is the fast stage, high lane counts its underflows
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [HALF_W-1:0] seg;
      assign seg = count[g*HALF_W +: HALF_W];
      if (g == 0) begin : g_fast
         assign split_nxt[g*HALF_W +: HALF_W] =
            (seg == '0) ? load_val[g*HALF_W +: HALF_W] : seg - 1'b1;
      end else begin : g_slow
         assign split_nxt[g*HALF_W +: HALF_W] = lo_zero ? seg - 1'b1 : seg;
      end
   end

   assign step_nxt = (md == CDT_SPLIT) ? split_nxt : full_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         cap_val <= '0;
      end else begin
         if (load_req)     count <= reload_src;
         else if (dec_req) count <= step_nxt;
         if (cap_req)      cap_val <= ~count;
      end
   end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] load_val,
   input  logic             chain_en,
   input  logic             start_on_trig,
   input  logic             reload_on_trig,
   input  logic             stop_on_timeout,
   input  logic             trig_in,
   input  logic             chain_tick,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_val,
   output logic             timeout_pulse,
   output logic             flag_set
);

   if (CNT_W < 4 || (CNT_W % 2) != 0) begin : g_bad_width
      $error("cdt_channel: CNT_W must be even and at least 4");
   end

   logic trig_evt_w, load_w, dec_w, cap_w, run_w, en_q_w, expire_w, zero_w;

   cdt_trig_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .trig_evt (trig_evt_w)
   );

   cdt_ctrl u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .en              (en),
      .mode            (mode),
      .chain_en        (chain_en),
      .chain_tick      (chain_tick),
      .start_on_trig   (start_on_trig),
      .reload_on_trig  (reload_on_trig),
      .stop_on_timeout (stop_on_timeout),
      .trig_evt        (trig_evt_w),
      .cnt_zero        (zero_w),
      .load_req        (load_w),
      .dec_req         (dec_w),
      .cap_req         (cap_w),
      .run_st          (run_w),
      .en_q            (en_q_w),
      .expire_q        (expire_w)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .load_val (load_val),
      .load_req (load_w),
      .dec_req  (dec_w),
      .cap_req  (cap_w),
      .count    (count),
      .cap_val  (cap_val),
      .cnt_zero (zero_w)
   );

   assign timeout_pulse = expire_w;
   assign flag_set      = expire_w;

endmodule

// File: rtl/cdt_channel_chk.sv
module cdt_channel_chk
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             en_q,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] load_val,
   input logic             chain_en,
   input logic             chain_tick,
   input logic             reload_on_trig,
   input logic             stop_on_timeout,
   input logic             trig_evt,
   input logic             run_st,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cap_val,
   input logic             timeout_pulse
);

   localparam int HALF_W = CNT_W / 2;

   logic [HALF_W-1:0] hi_w, lo_w, ld_lo_w;
   logic              live;

   assign hi_w    = count[CNT_W-1:HALF_W];
   assign lo_w    = count[HALF_W-1:0];
   assign ld_lo_w = load_val[HALF_W-1:0];
   assign live    = en && en_q && run_st && !(reload_on_trig && trig_evt);

   assert_enable_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_q) |=> count == (($past(mode) == CDT_CAPTURE) ? {CNT_W{1'b1}} : $past(load_val)));

   assert_periodic_expire_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (live && mode == CDT_PERIODIC && !chain_en && count == '0)
      |=> (timeout_pulse && count == $past(load_val)));

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_pulse && $past(load_val) > 1) |=> !timeout_pulse);

   assert_split_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && mode == CDT_SPLIT && !chain_en && lo_w == '0 && hi_w != '0)
      |=> (hi_w == $past(hi_w) - 1'b1 && lo_w == $past(ld_lo_w)));

   assert_capture_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q && run_st && mode == CDT_CAPTURE && trig_evt) |=> cap_val == ~$past(count));

   assert_chain_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && en_q && run_st && chain_en && !chain_tick && mode != CDT_ACCUM && !trig_evt)
      |=> ($stable(count) && !timeout_pulse));

   assert_halt_after_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_pulse && $past(stop_on_timeout) && en && en_q) |=> ($stable(count) && !timeout_pulse));

   assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(count) && !timeout_pulse));

endmodule

bind cdt_channel cdt_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .en              (en),
   .en_q            (en_q_w),
   .mode            (mode),
   .load_val        (load_val),
   .chain_en        (chain_en),
   .chain_tick      (chain_tick),
   .reload_on_trig  (reload_on_trig),
   .stop_on_timeout (stop_on_timeout),
   .trig_evt        (trig_evt_w),
   .run_st          (run_w),
   .count           (count),
   .cap_val         (cap_val),
   .timeout_pulse   (timeout_pulse)
);

// File: tb/cdt_channel_tb_top.sv
module cdt_channel_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] load_val = '0;
   logic         chain_en = 1'b0, start_on_trig = 1'b0, reload_on_trig = 1'b0;
   logic         stop_on_timeout = 1'b0, trig_in = 1'b0, chain_tick = 1'b0;
   logic [W-1:0] count, cap_val;
   logic         timeout_pulse, flag_set;

   always #10 clk = ~clk;

   cdt_channel #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .load_val(load_val),
      .chain_en(chain_en), .start_on_trig(start_on_trig), .reload_on_trig(reload_on_trig),
      .stop_on_timeout(stop_on_timeout), .trig_in(trig_in), .chain_tick(chain_tick),
      .count(count), .cap_val(cap_val), .timeout_pulse(timeout_pulse), .flag_set(flag_set)
   );

   typedef struct {
      int           cyc;
      logic [W-1:0] cnt;
      logic         pls;
      bit           cap_chk;
      logic [W-1:0] cap;
      string        tag;
   } exp_t;

   exp_t sb_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(int off, logic [W-1:0] c, logic p, string tag);
      exp_t e;
      e.cyc = cyc + off; e.cnt = c; e.pls = p; e.cap_chk = 1'b0; e.cap = '0; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic push_cap(int off, logic [W-1:0] c, logic [W-1:0] cv, string tag);
      exp_t e;
      e.cyc = cyc + off; e.cnt = c; e.pls = 1'b0; e.cap_chk = 1'b1; e.cap = cv; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compare the scoreboard head in the cycle it is due
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
         n_chk++; n_err++;
         $display("FAIL %s: item for cycle %0d not compared (now %0d, expected compare)",
                  sb_q[0].tag, sb_q[0].cyc, cyc);
         void'(sb_q.pop_front());
      end
      if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (count !== e.cnt || timeout_pulse !== e.pls || flag_set !== e.pls ||
             (e.cap_chk && cap_val !== e.cap)) begin
            n_err++;
            $display("FAIL %s: cycle %0d count=%0h pulse=%0b flag=%0b cap=%0h expected count=%0h pulse=%0b cap=%0h",
                     e.tag, cyc, count, timeout_pulse, flag_set, cap_val, e.cnt, e.pls, e.cap);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart();
      en = 1'b0; chain_en = 1'b0; start_on_trig = 1'b0; reload_on_trig = 1'b0;
      stop_on_timeout = 1'b0; trig_in = 1'b0; chain_tick = 1'b0;
      step(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete (cycle %0d, expected completion)", cyc);
      finish_run();
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      // reset state
      n_chk++;
      if (count !== '0 || timeout_pulse !== 1'b0 || flag_set !== 1'b0 || cap_val !== '0) begin
         n_err++;
         $display("FAIL reset: count=%0h pulse=%0b cap=%0h expected 0 0 0", count, timeout_pulse, cap_val);
      end

      // R1 periodic, R2 pulse width, R3 deferred load, R11 disable/re-enable
      restart();
      mode = 2'd0; load_val = 8'd4; en = 1'b1;
      push(1, 8'd4, 1'b0, "R1"); push(2, 8'd3, 1'b0, "R1"); push(3, 8'd2, 1'b0, "R3");
      push(4, 8'd1, 1'b0, "R3"); push(5, 8'd0, 1'b0, "R1");
      push(6, 8'd6, 1'b1, "R3"); push(7, 8'd5, 1'b0, "R2");
      step(1); load_val = 8'd6;
      step(6); en = 1'b0;
      push(1, 8'd5, 1'b0, "R11"); push(2, 8'd5, 1'b0, "R11");
      step(2); load_val = 8'd3; en = 1'b1;
      push(1, 8'd3, 1'b0, "R11");
      step(1);

      // R4 split halves
      restart();
      mode = 2'd1; load_val = 8'h12; en = 1'b1;
      push(1, 8'h12, 1'b0, "R4"); push(2, 8'h11, 1'b0, "R4"); push(3, 8'h10, 1'b0, "R4");
      push(4, 8'h02, 1'b0, "R4"); push(5, 8'h01, 1'b0, "R4"); push(6, 8'h00, 1'b0, "R4");
      push(7, 8'h12, 1'b1, "R4"); push(8, 8'h11, 1'b0, "R4");
      step(8);

      // R5 accumulate, R12 edge-only triggers
      restart();
      mode = 2'd2; load_val = 8'd2; en = 1'b1;
      push(1, 8'd2, 1'b0, "R5"); push(2, 8'd2, 1'b0, "R5"); push(3, 8'd2, 1'b0, "R12");
      push(5, 8'd1, 1'b0, "R5"); push(6, 8'd1, 1'b0, "R5"); push(7, 8'd0, 1'b0, "R5");
      push(9, 8'd2, 1'b1, "R5"); push(10, 8'd2, 1'b0, "R5");
      step(1); trig_in = 1'b1;
      step(2); trig_in = 1'b0;
      step(1); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(1); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(1); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(1);

      // R6 capture: all-ones start, inverted latch, wrap
      restart();
      mode = 2'd3; load_val = 8'h40; en = 1'b1;
      push(1, 8'hFF, 1'b0, "R6"); push(2, 8'hFE, 1'b0, "R6"); push(4, 8'hFC, 1'b0, "R6");
      push_cap(5, 8'hFB, 8'h03, "R6");
      push(256, 8'h00, 1'b0, "R6"); push(257, 8'hFF, 1'b1, "R6"); push(258, 8'hFE, 1'b0, "R6");
      step(4); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(253);

      // R7 chained stepping
      restart();
      mode = 2'd0; chain_en = 1'b1; load_val = 8'd3; en = 1'b1;
      push(1, 8'd3, 1'b0, "R7"); push(3, 8'd3, 1'b0, "R7"); push(4, 8'd2, 1'b0, "R7");
      push(5, 8'd2, 1'b0, "R7"); push(6, 8'd1, 1'b0, "R7"); push(8, 8'd0, 1'b0, "R7");
      push(9, 8'd0, 1'b0, "R7"); push(10, 8'd3, 1'b1, "R7");
      step(3);
      for (int k = 0; k < 4; k++) begin
         chain_tick = 1'b1; step(1);
         chain_tick = 1'b0; step(1);
      end

      // R8 start on trigger
      restart();
      mode = 2'd0; start_on_trig = 1'b1; load_val = 8'd3; en = 1'b1;
      push(1, 8'd3, 1'b0, "R8"); push(3, 8'd3, 1'b0, "R8"); push(4, 8'd3, 1'b0, "R8");
      push(5, 8'd2, 1'b0, "R8"); push(6, 8'd1, 1'b0, "R8");
      step(3); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(3);

      // R9 reload on trigger
      restart();
      mode = 2'd0; reload_on_trig = 1'b1; load_val = 8'd5; en = 1'b1;
      push(1, 8'd5, 1'b0, "R9"); push(2, 8'd4, 1'b0, "R9"); push(3, 8'd3, 1'b0, "R9");
      push(4, 8'd5, 1'b0, "R9"); push(5, 8'd4, 1'b0, "R9");
      step(3); trig_in = 1'b1;
      step(1); trig_in = 1'b0;
      step(2);

      // R10 halt after first expiry
      restart();
      mode = 2'd0; stop_on_timeout = 1'b1; load_val = 8'd2; en = 1'b1;
      push(1, 8'd2, 1'b0, "R10"); push(2, 8'd1, 1'b0, "R10"); push(3, 8'd0, 1'b0, "R10");
      push(4, 8'd2, 1'b1, "R10"); push(5, 8'd2, 1'b0, "R10"); push(8, 8'd2, 1'b0, "R10");
      step(9);

      step(2);
      if (sb_q.size() != 0) begin
         n_chk++; n_err++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule